// File: doc/BRIEF.md
# Serial Shift Unit with Edge Counter

This block is the data path of a small general-purpose serial port. An 8-bit shift register and a 4-bit counter advance together on one clock event. The event comes from one of four settings of a select input: a software strobe, a timer overflow strobe, or the external serial clock pin with sampling on its rising or on its falling edge. The host reads and writes both the register and the counter directly. Software sets the counter so that its wrap from 15 to 0 marks the end of a transfer. That wrap sets a sticky overflow flag, and the flag can raise an interrupt.

The register shifts left and takes the serial input into bit 0. Its top bit goes to an output holding stage. In the external-clock settings that stage is reloaded only on the clock edge opposite to the sampling edge, so outgoing data changes half a serial period away from the moment incoming data is taken. In the external settings the counter advances on both edges of the serial clock, so it counts edges and not bits. A wire-mode input sends the held bit either to a push-pull data-out pin or to a pull-low enable for an open-drain data line. Bus clock holding and start-condition detection belong to a separate block.

Top module: `serial_shift_unit`

## Requirements
- R1: After reset the data register, the counter, the overflow flag, the held output bit and the irq output are all 0.
- R2: A data write (`wr_data_en`) or a counter write (`wr_cnt_en`) can be read back on `rd_data` or `rd_cnt` one cycle later. A write wins over a shift or count in the same cycle.
- R3: On each sampling event the data register becomes {data[6:0], din}. Sampling events are a `sw_strobe` pulse when clk_sel=0, a `tmr_ovf` pulse when clk_sel=1, a rising edge of `sck_in` when clk_sel=2, and a falling edge of `sck_in` when clk_sel=3.
- R4: With clk_sel 0 or 1, the counter advances by 1 on each sampling event. With clk_sel 2 or 3, it advances by 1 on every rising edge and every falling edge of `sck_in`.
- R5: A count event while the counter holds 15 wraps it to 0 and sets `ovf_flag`. The flag stays set until `flag_clr` is pulsed. If a wrap and a clear fall in the same cycle, the flag is set.
- R6: `irq` is 1 exactly when `ovf_flag` and `irq_en` are both 1.
- R7: With wire_mode=0, `dout_3w` shows the held bit and `sda_pull_low` is 0. With wire_mode=1, `dout_3w` is 0 and `sda_pull_low` is the inverse of the held bit.
- R8: With clk_sel 0 or 1, the held bit takes the register's bit 7 on every cycle. With clk_sel 2 or 3, it takes bit 7 only on the `sck_in` edge opposite to the sampling edge, and it keeps its value across the sampling edge.
- R9: A strobe from a source that clk_sel does not select has no effect on the register or on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 2 | Event source: 0 software, 1 timer, 2 external rising sample, 3 external falling sample |
| wire_mode | input | 1 | 0 push-pull data out, 1 open-drain data line |
| wr_data_en | input | 1 | Load `wdata` into the data register |
| wr_cnt_en | input | 1 | Load `wdata[3:0]` into the counter |
| wdata | input | 8 | Host write data |
| flag_clr | input | 1 | Clear the overflow flag |
| irq_en | input | 1 | Interrupt enable |
| sw_strobe | input | 1 | Software clock strobe, one cycle per event |
| tmr_ovf | input | 1 | Timer overflow strobe, one cycle per event |
| sck_in | input | 1 | External serial clock, asynchronous |
| din | input | 1 | Serial data input |
| rd_data | output | 8 | Data register contents |
| rd_cnt | output | 4 | Counter contents |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |
| dout_3w | output | 1 | Push-pull serial data output |
| sda_pull_low | output | 1 | Pull-low enable for the open-drain data line |

## Verification
The assertions assume that `sw_strobe` and `tmr_ovf` are single-cycle pulses. They also assume that `sck_in` stays level for at least two system clocks, so every edge reaches the edge detector as one clean transition. In addition they assume that `din` is stable in the cycle in which a synchronized edge is detected. The stimulus holds every strobe for exactly one cycle. It changes `din` only while the serial clock is quiet and waits several cycles after each `sck_in` change. Mode settings change only between events.

// File: rtl/serial_shift_unit.sv
module serial_shift_unit #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    clk_sel,
  input  logic          wire_mode,
  input  logic          wr_data_en,
  input  logic          wr_cnt_en,
  input  logic [DW-1:0] wdata,
  input  logic          flag_clr,
  input  logic          irq_en,
  input  logic          sw_strobe,
  input  logic          tmr_ovf,
  input  logic          sck_in,
  input  logic          din,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] rd_cnt,
  output logic          ovf_flag,
  output logic          irq,
  output logic          dout_3w,
  output logic          sda_pull_low
);
  localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};

  logic [2:0]    sck_q;
  logic [DW-1:0] shreg;
  logic [CW-1:0] cnt;
  logic          flag, held;
  logic          ext, rise, fall, samp, cnt_evt, opp, wrap;

  assign ext  = clk_sel[1];
  assign rise = sck_q[1] & ~sck_q[2];
  assign fall = ~sck_q[1] & sck_q[2];

  assign samp    = ext ? (clk_sel[0] ? fall : rise) : (clk_sel[0] ? tmr_ovf : sw_strobe);
  assign cnt_evt = ext ? (rise | fall) : samp;
  assign opp     = ext ? (clk_sel[0] ? rise : fall) : 1'b1;
  assign wrap    = cnt_evt && !wr_cnt_en && (cnt == CNT_TOP);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_q <= '0;
    else        sck_q <= {sck_q[1:0], sck_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          shreg <= '0;
    else if (wr_data_en) shreg <= wdata;
    else if (samp)       shreg <= {shreg[DW-2:0], din};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         cnt <= '0;
    else if (wr_cnt_en) cnt <= wdata[CW-1:0];
    else if (cnt_evt)   cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        flag <= 1'b0;
    else if (wrap)     flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   held <= 1'b0;
    else if (opp) held <= shreg[DW-1];

  assign rd_data      = shreg;
  assign rd_cnt       = cnt;
  assign ovf_flag     = flag;
  assign irq          = flag & irq_en;
  assign dout_3w      = ~wire_mode & held;
  assign sda_pull_low = wire_mode & ~held;
endmodule

module serial_shift_unit_chk #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    clk_sel,
  input logic          wire_mode,
  input logic          wr_data_en,
  input logic          wr_cnt_en,
  input logic          flag_clr,
  input logic          samp,
  input logic          cnt_evt,
  input logic          opp,
  input logic          din,
  input logic          held,
  input logic [DW-1:0] rd_data,
  input logic [CW-1:0] rd_cnt,
  input logic          ovf_flag,
  input logic          irq,
  input logic          dout_3w
);
  assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    samp && !wr_data_en |=> rd_data == {$past(rd_data[DW-2:0]), $past(din)});
  assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_evt && !wr_cnt_en |=> $stable(rd_cnt));
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_evt && !wr_cnt_en |=> rd_cnt == $past(rd_cnt) + 1'b1);
  assert_wrap_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_evt && !wr_cnt_en && rd_cnt == {CW{1'b1}} |=> ovf_flag);
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !flag_clr |=> ovf_flag);
  assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag);
  assert_steer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wire_mode |-> !dout_3w);
  assert_hold_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel[1] && !opp |=> $stable(held));
endmodule

bind serial_shift_unit serial_shift_unit_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wire_mode(wire_mode),
  .wr_data_en(wr_data_en), .wr_cnt_en(wr_cnt_en), .flag_clr(flag_clr),
  .samp(samp), .cnt_evt(cnt_evt), .opp(opp), .din(din), .held(held),
  .rd_data(rd_data), .rd_cnt(rd_cnt), .ovf_flag(ovf_flag), .irq(irq),
  .dout_3w(dout_3w)
);

// File: tb/serial_shift_unit_bench.sv
module serial_shift_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic wire_mode = 1'b0, wr_data_en = 1'b0, wr_cnt_en = 1'b0;
  logic [7:0] wdata = '0;
  logic flag_clr = 1'b0, irq_en = 1'b0, sw_strobe = 1'b0, tmr_ovf = 1'b0;
  logic sck_in = 1'b0, din = 1'b0;
  logic [7:0] rd_data;
  logic [3:0] rd_cnt;
  logic ovf_flag, irq, dout_3w, sda_pull_low;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  serial_shift_unit u_serial_shift_unit (.*);

  localparam int NV = 6;
  localparam logic [16:0] VEC [NV] = '{
    {8'hA5, 1'b1, 8'h4B}, {8'hA5, 1'b0, 8'h4A}, {8'h80, 1'b0, 8'h00},
    {8'h01, 1'b1, 8'h03}, {8'hFF, 1'b0, 8'hFE}, {8'h3C, 1'b1, 8'h79}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_data(input logic [7:0] v);
    wdata = v; wr_data_en = 1'b1; @(negedge clk); wr_data_en = 1'b0;
  endtask

  task automatic wr_cnt(input logic [3:0] v);
    wdata = {4'h0, v}; wr_cnt_en = 1'b1; @(negedge clk); wr_cnt_en = 1'b0;
  endtask

  task automatic sw_pulse(input logic clr);
    sw_strobe = 1'b1; flag_clr = clr; @(negedge clk); sw_strobe = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic tmr_pulse();
    tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0;
  endtask

  task automatic sck_set(input logic v);
    sck_in = v; idle(6);
  endtask

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(2); rst_n = 1'b1; idle(1);
    chk("R1 data", rd_data, 8'h00);
    chk("R1 cnt", {4'h0, rd_cnt}, 8'h00);
    chk("R1 flag", {7'h0, ovf_flag}, 8'h00);
    chk("R1 irq", {7'h0, irq}, 8'h00);
    chk("R1 dout", {7'h0, dout_3w}, 8'h00);
    chk("R7 sda idle", {7'h0, sda_pull_low}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr_data(VEC[i][16:9]);
      din = VEC[i][8];
      sw_pulse(1'b0);
      chk("R3 shift", rd_data, VEC[i][7:0]);
    end
    chk("R4 sw count", {4'h0, rd_cnt}, 8'h06);

    wr_cnt(4'd9);
    chk("R2 cnt write", {4'h0, rd_cnt}, 8'h09);
    wdata = 8'h12; wr_data_en = 1'b1; sw_strobe = 1'b1; @(negedge clk);
    wr_data_en = 1'b0; sw_strobe = 1'b0;
    chk("R2 write wins", rd_data, 8'h12);
    chk("R4 count with write", {4'h0, rd_cnt}, 8'h0A);

    wr_cnt(4'd14);
    sw_pulse(1'b0);
    chk("R5 no flag at 15", {7'h0, ovf_flag}, 8'h00);
    sw_pulse(1'b0);
    chk("R5 wrap cnt", {4'h0, rd_cnt}, 8'h00);
    chk("R5 wrap flag", {7'h0, ovf_flag}, 8'h01);
    chk("R6 irq masked", {7'h0, irq}, 8'h00);
    irq_en = 1'b1; idle(1);
    chk("R6 irq raised", {7'h0, irq}, 8'h01);
    sw_pulse(1'b0);
    chk("R5 sticky", {7'h0, ovf_flag}, 8'h01);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk("R5 cleared", {7'h0, ovf_flag}, 8'h00);
    chk("R6 irq dropped", {7'h0, irq}, 8'h00);
    wr_cnt(4'd15);
    sw_pulse(1'b1);
    chk("R5 set beats clear", {7'h0, ovf_flag}, 8'h01);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    irq_en = 1'b0;

    wr_data(8'h5A); wr_cnt(4'd0);
    tmr_pulse();
    chk("R9 tmr ignored cnt", {4'h0, rd_cnt}, 8'h00);
    chk("R9 tmr ignored data", rd_data, 8'h5A);
    clk_sel = 2'd1; idle(1);
    sw_pulse(1'b0);
    chk("R9 sw ignored cnt", {4'h0, rd_cnt}, 8'h00);
    din = 1'b0;
    tmr_pulse();
    chk("R4 tmr count", {4'h0, rd_cnt}, 8'h01);
    chk("R3 tmr shift", rd_data, 8'hB4);

    clk_sel = 2'd0;
    wr_data(8'h80); idle(1);
    chk("R8 internal follows", {7'h0, dout_3w}, 8'h01);
    clk_sel = 2'd2; din = 1'b0; wr_cnt(4'd0);
    sck_set(1'b1);
    chk("R3 ext rise shift", rd_data, 8'h00);
    chk("R4 ext rise count", {4'h0, rd_cnt}, 8'h01);
    chk("R8 held across sample", {7'h0, dout_3w}, 8'h01);
    sck_set(1'b0);
    chk("R4 ext fall count", {4'h0, rd_cnt}, 8'h02);
    chk("R8 updates on opposite", {7'h0, dout_3w}, 8'h00);
    wire_mode = 1'b1; idle(1);
    chk("R7 2w dout off", {7'h0, dout_3w}, 8'h00);
    chk("R7 2w pull low", {7'h0, sda_pull_low}, 8'h01);

    clk_sel = 2'd3; wr_data(8'hC0); din = 1'b1;
    sck_set(1'b1);
    chk("R3 fall mode no shift on rise", rd_data, 8'hC0);
    chk("R4 fall mode rise count", {4'h0, rd_cnt}, 8'h03);
    chk("R8 fall mode load on rise", {7'h0, sda_pull_low}, 8'h00);
    sck_set(1'b0);
    chk("R3 fall mode shift", rd_data, 8'h81);
    chk("R4 fall mode fall count", {4'h0, rd_cnt}, 8'h04);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule